// File: doc/BRIEF.md
# Descriptor Entry Chain Walker

This block holds a device descriptor image in an internal byte RAM and walks the chain of self-sized entries that follows the fixed 22-byte header. Software or a loader engine first fills the RAM through a byte-write port. It then pulses `start`. The walker reads the image size from the header and visits one entry per cycle, beginning at byte 22. Generic entries are passed over. Each port entry yields one record on a valid/ready output.

A port record carries the entry's port index and its disabled flag. For a well-formed enabled entry it also carries the link number and the dual-link partner, if one exists. An enabled port entry whose length is wrong still yields a record, flagged as malformed, and the walk goes on. A broken chain stops the walk with an overrun indication. A one-cycle `done` pulse marks the end of every walk, whether it finished normally or was aborted.

Top module: `drom_chain_walker`

## Requirements
- R1: After reset, `rec_valid`, `done` and `overrun` are 0.
- R2: The image size is a 10-bit length field plus 13. The field's low 8 bits are byte 14, and its bits 9:8 are bits 1:0 of byte 15. The upper six bits of byte 15 are ignored. The walk starts at byte 22 and runs while the position is below the size. If the size is 22 or less, the walk ends with no records and no overrun.
- R3: The entry layout is as follows. Byte 0 is the entry length in bytes. In byte 1, bits 5:0 are the index, bit 6 is the disabled flag, and bit 7 is the type (1 = port, 0 = generic). A generic entry produces no record. After each accepted entry, the position advances by that entry's length.
- R4: An enabled port entry of exactly 8 bytes gives a record with the following fields. `rec_link` is bit 4 of byte 2. `rec_has_dual` is bit 7 of byte 2. `rec_dual_port` is bits 5:0 of byte 3 when `rec_has_dual` is 1, and 0 otherwise. `rec_bad_len` and `rec_disabled` are 0.
- R5: An enabled port entry whose length is not 8 gives a record with `rec_bad_len` = 1 and the link and partner fields at 0. The walk then continues with the next entry.
- R6: A disabled port entry, of any length, gives a record with `rec_disabled` = 1. Its link, partner and `rec_bad_len` fields are 0.
- R7: The walk aborts, with `overrun` = 1 at `done`, in any of three cases: the entry length is 0, the position is exactly one byte below the size, or position plus length exceeds the size. No record follows an abort. An entry that ends exactly at the size is accepted.
- R8: Records leave in chain order. A record stays valid, with unchanged fields, until it is taken with `rec_ready`.
- R9: `done` is high for exactly one cycle and never together with `rec_valid`. `overrun` is valid at `done` and held until the next start. For a chain of k generic entries, `done` is high k+1 cycles after the edge that samples `start`.
- R10: A `start` pulse that arrives while a walk is in progress is ignored. The walk continues and emits the same records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Image byte write enable |
| wr_addr | input | AW | Image byte address |
| wr_data | input | 8 | Image byte data |
| start | input | 1 | Begin a walk (ignored while busy) |
| rec_valid | output | 1 | Port record available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_index | output | 6 | Port index |
| rec_disabled | output | 1 | Port marked disabled |
| rec_bad_len | output | 1 | Enabled port entry had the wrong length |
| rec_link | output | 1 | Link number |
| rec_has_dual | output | 1 | Dual-link partner exists |
| rec_dual_port | output | 6 | Partner port number |
| done | output | 1 | One-cycle end-of-walk pulse |
| overrun | output | 1 | Walk aborted on a malformed chain |

## Verification
The first entry is evaluated one edge after `start` is sampled, and each later entry takes one further edge. A record is registered on the edge that evaluates its entry and is taken on the first edge at which `rec_ready` is high. The bench therefore samples `rec_valid` at each falling edge, picks `rec_ready` there, and counts a record as taken only when both are high before the following rising edge. A directed run of k generic entries counts edges from the start edge and expects `done` at exactly edge k+1.

// File: rtl/drom_chain_walker.sv
module drom_chain_walker #(
  parameter int DEPTH     = 1037,
  parameter int HDR_BYTES = 22,
  parameter int SIZE_BIAS = 13,
  parameter int PORT_LEN  = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 256)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          start,
  output logic          rec_valid,
  input  logic          rec_ready,
  output logic [5:0]    rec_index,
  output logic          rec_disabled,
  output logic          rec_bad_len,
  output logic          rec_link,
  output logic          rec_has_dual,
  output logic [5:0]    rec_dual_port,
  output logic          done,
  output logic          overrun
);

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_EMIT} st_t;

  logic [7:0]    mem [DEPTH];
  st_t           st;
  logic [PW-1:0] pos;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  function automatic logic [7:0] rd(input logic [PW-1:0] a);
    if (a < PW'(DEPTH)) return mem[a[AW-1:0]];
    return 8'h00;
  endfunction

  logic [7:0] b15, b14, len, hdr, b2, b3;
  assign b14 = rd(PW'(14));
  assign b15 = rd(PW'(15));
  assign len = rd(pos);
  assign hdr = rd(pos + PW'(1));
  assign b2  = rd(pos + PW'(2));
  assign b3  = rd(pos + PW'(3));

  logic [PW-1:0] img_size;
  assign img_size = PW'({b15[1:0], b14}) + PW'(SIZE_BIAS);

  logic at_end, bad_chain, len_ok;
  assign at_end    = pos >= img_size;
  assign bad_chain = (len == 8'd0) || (pos + PW'(1) == img_size) ||
                     (pos + PW'(len) > img_size);
  assign len_ok    = len == 8'(PORT_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      pos           <= '0;
      done          <= 1'b0;
      overrun       <= 1'b0;
      rec_valid     <= 1'b0;
      rec_index     <= '0;
      rec_disabled  <= 1'b0;
      rec_bad_len   <= 1'b0;
      rec_link      <= 1'b0;
      rec_has_dual  <= 1'b0;
      rec_dual_port <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pos     <= PW'(HDR_BYTES);
          overrun <= 1'b0;
          st      <= S_WALK;
        end
        S_WALK: begin
          if (at_end) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (bad_chain) begin
            done    <= 1'b1;
            overrun <= 1'b1;
            st      <= S_IDLE;
          end else begin
            pos <= pos + PW'(len);
            if (hdr[7]) begin
              rec_valid     <= 1'b1;
              rec_index     <= hdr[5:0];
              rec_disabled  <= hdr[6];
              rec_bad_len   <= !hdr[6] && !len_ok;
              rec_link      <= !hdr[6] && len_ok && b2[4];
              rec_has_dual  <= !hdr[6] && len_ok && b2[7];
              rec_dual_port <= (!hdr[6] && len_ok && b2[7]) ? b3[5:0] : 6'd0;
              st            <= S_EMIT;
            end
          end
        end
        S_EMIT: if (rec_ready) begin
          rec_valid <= 1'b0;
          st        <= S_WALK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_index) &&
      $stable(rec_link) && $stable(rec_has_dual) && $stable(rec_dual_port) &&
      $stable(rec_disabled) && $stable(rec_bad_len));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && rec_valid));

  assert_disabled_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_disabled |-> !rec_link && !rec_has_dual && !rec_bad_len);

  assert_badlen_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_bad_len |-> !rec_link && !rec_has_dual && rec_dual_port == 6'd0);

  assert_no_rec_after_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !$past(start) |-> !$rose(rec_valid));

endmodule

// File: tb/drom_chain_walker_test.sv
module drom_chain_walker_test;
  localparam int DEPTH = 1037;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, start = 1'b0, rec_ready = 1'b1;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rec_valid, rec_disabled, rec_bad_len, rec_link, rec_has_dual, done, overrun;
  logic [5:0] rec_index, rec_dual_port;

  always #2 clk = ~clk;

  drom_chain_walker #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_index(rec_index), .rec_disabled(rec_disabled), .rec_bad_len(rec_bad_len),
    .rec_link(rec_link), .rec_has_dual(rec_has_dual), .rec_dual_port(rec_dual_port),
    .done(done), .overrun(overrun));

  logic [7:0]  img [DEPTH];
  logic [15:0] exp_rec [256];
  int exp_n;
  bit exp_ovr;
  int n_chk = 0, n_fail = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int img_size();
    return int'({img[15][1:0], img[14]}) + 13;
  endfunction

  function automatic void ref_walk();
    int size = img_size();
    int pos = 22;
    exp_n = 0;
    exp_ovr = 0;
    while (pos < size) begin
      int l = int'(img[pos]);
      logic [7:0] h, c2, c3;
      if (l == 0 || pos + 1 == size || pos + l > size) begin
        exp_ovr = 1;
        break;
      end
      h = img[pos + 1];
      c2 = img[pos + 2];
      c3 = img[pos + 3];
      if (h[7] && exp_n < 256) begin
        if (h[6])
          exp_rec[exp_n] = {1'b0, 1'b1, h[5:0], 8'h00};
        else if (l != 8)
          exp_rec[exp_n] = {1'b1, 1'b0, h[5:0], 8'h00};
        else
          exp_rec[exp_n] = {1'b0, 1'b0, h[5:0], c2[4], c2[7], c2[7] ? c3[5:0] : 6'd0};
        exp_n++;
      end
      pos += l;
    end
  endfunction

  task automatic clear_img();
    for (int i = 0; i < DEPTH; i++) img[i] = 8'h00;
  endtask

  task automatic set_size(int size);
    logic [9:0] dl = 10'(size - 13);
    img[14] = dl[7:0];
    img[15] = {6'($urandom), dl[9:8]};
  endtask

  task automatic load(int upto);
    int top = (upto < 24) ? 24 : upto;
    if (top > DEPTH) top = DEPTH;
    for (int i = 0; i < top; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = AW'(i);
      wr_data = img[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int rdy_pct, bit poke, string req);
    int got = 0;
    bit seen = 0, poked = 0;
    ref_walk();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 5000; c++) begin
      if (done) begin
        seen = 1;
        chk(got == exp_n, req, "record count", got, exp_n);
        chk(overrun == exp_ovr, req, "overrun at done", int'(overrun), int'(exp_ovr));
        break;
      end
      start = 1'b0;
      if (poke && rec_valid && !poked) begin
        start = 1'b1;
        poked = 1;
        rec_ready = 1'b0;
      end else
        rec_ready = (int'($urandom % 100) < rdy_pct);
      if (rec_valid && rec_ready) begin
        logic [15:0] act = {rec_bad_len, rec_disabled, rec_index, rec_link, rec_has_dual, rec_dual_port};
        if (got < exp_n)
          chk(act == exp_rec[got], req, "record fields", int'(act), int'(exp_rec[got]));
        else
          chk(0, req, "extra record", int'(act), 0);
        got++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    rec_ready = 1'b1;
    if (!seen) chk(0, req, "done never seen", 0, 1);
  endtask

  task automatic put(inout int pos, input int l, input logic [7:0] h,
                     input logic [7:0] c2, input logic [7:0] c3);
    img[pos] = 8'(l);
    img[pos + 1] = h;
    if (l > 2) img[pos + 2] = c2;
    if (l > 3) img[pos + 3] = c3;
    for (int i = 4; i < l; i++) img[pos + i] = 8'($urandom);
    pos += l;
  endtask

  task automatic build_random();
    int pos = 22;
    int k = 1 + int'($urandom % 12);
    int m;
    clear_img();
    for (int i = 0; i < 22; i++) img[i] = 8'($urandom);
    for (int e = 0; e < k; e++) begin
      int t = int'($urandom % 4);
      logic [5:0] idx = 6'($urandom);
      if (t == 0)
        put(pos, 2 + int'($urandom % 20), {1'b0, 7'($urandom)}, 8'($urandom), 8'($urandom));
      else if (t == 1)
        put(pos, 2 + int'($urandom % 9), {2'b11, idx}, 8'($urandom), 8'($urandom));
      else
        put(pos, ($urandom % 5 == 0) ? 2 + int'($urandom % 11) : 8, {2'b10, idx},
            8'($urandom), 8'($urandom));
    end
    m = int'($urandom % 6);
    if (m == 0) set_size(pos - 1);
    else if (m == 1) begin img[pos] = 8'($urandom); set_size(pos + 1); end
    else if (m == 2) begin img[22] = 8'h00; set_size(pos); end
    else set_size(pos);
    load(pos + 2);
  endtask

  task automatic timed(int k, string req);
    int n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == k + 1, req, "done latency", n, k + 1);
    chk(overrun == 1'b0, req, "no overrun", int'(overrun), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int p;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rec_valid == 0, "R1", "rec_valid after reset", int'(rec_valid), 0);
    chk(done == 0, "R1", "done after reset", int'(done), 0);
    chk(overrun == 0, "R1", "overrun after reset", int'(overrun), 0);

    // R2 empty chain, size exactly 22, upper bits of byte 15 set
    clear_img(); img[14] = 8'd9; img[15] = 8'hFC; load(24);
    run(100, 0, "R2");
    timed(0, "R2");
    // R2 size below header
    clear_img(); img[14] = 8'd0; img[15] = 8'h00; load(24);
    run(100, 0, "R2");

    // R9 three generic entries -> done at edge 4
    clear_img(); p = 22;
    put(p, 4, 8'h05, 8'h00, 8'h00); put(p, 5, 8'h41, 8'h00, 8'h00); put(p, 6, 8'h3F, 8'h00, 8'h00);
    set_size(p); load(p);
    timed(3, "R9");
    run(100, 0, "R3");

    // R4 exact-fit port entries, with and without partner
    clear_img(); p = 22;
    put(p, 8, 8'h83, 8'h90, 8'hC5); put(p, 3, 8'h11, 8'h00, 8'h00); put(p, 8, 8'h84, 8'h10, 8'h3F);
    set_size(p); load(p);
    run(100, 0, "R4");
    run(40, 0, "R8");

    // R5 wrong length then good entry; R6 disabled short entry
    clear_img(); p = 22;
    put(p, 6, 8'h8A, 8'h90, 8'h07); put(p, 3, 8'hC2, 8'h90, 8'h00); put(p, 8, 8'h8B, 8'h80, 8'h22);
    set_size(p); load(p);
    run(100, 0, "R5");
    run(100, 0, "R6");

    // R7 zero length
    clear_img(); p = 22;
    put(p, 8, 8'h81, 8'h10, 8'h00); img[p] = 8'h00; img[p + 1] = 8'h82;
    set_size(p + 10); load(p + 10);
    run(100, 0, "R7");
    // R7 one byte before end
    clear_img(); p = 22;
    put(p, 8, 8'h81, 8'h00, 8'h00); img[p] = 8'h08;
    set_size(p + 1); load(p + 2);
    run(100, 0, "R7");
    // R7 entry runs past end
    clear_img(); p = 22;
    put(p, 8, 8'h81, 8'h00, 8'h00); put(p, 8, 8'h82, 8'h80, 8'h01);
    set_size(p - 1); load(p);
    run(100, 0, "R7");

    // R10 start during a walk is ignored
    clear_img(); p = 22;
    put(p, 8, 8'h85, 8'h90, 8'h02); put(p, 8, 8'h86, 8'h10, 8'h00);
    set_size(p); load(p);
    run(100, 1, "R10");

    for (int r = 0; r < 30; r++) begin
      build_random();
      run(30 + int'($urandom % 71), (r % 7) == 3, "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule